// File: doc/BRIEF.md
# Start-up Delay Sequencer

This block keeps the processor core halted after a reset, or after a wake-up from a deep sleep mode, until the selected clock source has had time to settle. It counts ticks from two sources. Both arrive as single-cycle enables in the block's own clock domain. Oscillator ticks come from the selected system oscillator, and watchdog ticks come from the slow watchdog oscillator. The lengths of both delays are decoded from a 4-bit clock-source select and a 2-bit start-up select.

After a reset the sequence has two stages. A watchdog-tick stage runs first and lets the supply settle; the selection may set its length to zero. An oscillator-tick stage then lets the oscillator stabilise. A wake-up from sleep runs only the oscillator-tick stage. The block raises `cpu_run` once the final stage is complete. A sleep request lowers `cpu_run`, and the block then waits for a wake pulse.

The active-high synchronous `rst` input does two jobs. It resets the block, and it is the reset event that starts the full sequence. The source-select and start-up-select inputs are static configuration values and are decoded continuously. All tick counts are parameters, and the defaults give the full-length delays.

Top module: `startup_hold`

## Requirements
- R1: While `rst` is high, and in the cycle after it was sampled high, `cpu_run` is low.
- R2: After `rst` falls, the block counts W watchdog ticks and then O oscillator ticks, where W and O are the selected lengths. Oscillator ticks that arrive during the watchdog stage are not counted, and watchdog ticks that arrive during the oscillator stage are not counted. `cpu_run` rises in the cycle after the clock edge that samples the O-th oscillator tick, and not before.
- R3: A wake pulse that arrives while the block is asleep starts an oscillator-only stage of O ticks, and that stage ignores watchdog ticks. While asleep and before a wake pulse, the block ignores ticks of both kinds.
- R4: Crystal family, source select 10 to 15. The selection index is {src_sel[0], sut_sel}, with sut_sel as the low two bits. Index 0 gives 258 oscillator ticks plus 4096 watchdog ticks, and index 1 gives 258 plus 65536. Index 2 gives 1024 plus 0, index 3 gives 1024 plus 4096, and index 4 gives 1024 plus 65536. Index 5 gives 16384 plus 0, index 6 gives 16384 plus 4096, and index 7 gives 16384 plus 65536.
- R5: Low-frequency crystal, source select 9. sut_sel 0 gives 1024 plus 4096, sut_sel 1 gives 1024 plus 65536, and sut_sel 2 gives 32768 plus 65536. The reserved code 3 also gives 32768 plus 65536.
- R6: External RC family, source select 5 to 8. sut_sel 0 gives 18 plus 0, sut_sel 1 gives 18 plus 4096, sut_sel 2 gives 18 plus 65536, and sut_sel 3 gives 6 plus 4096.
- R7: Internal RC family (source select 1 to 4) and external clock (source select 0). sut_sel 0 gives 6 plus 0, sut_sel 1 gives 6 plus 4096, and sut_sel 2 gives 6 plus 65536. The reserved code 3 also gives 6 plus 65536. The default setting, source 1 with sut_sel 2, therefore gives 6 plus 65536.
- R8: When the selected watchdog length is zero, oscillator ticks count from the first cycle after `rst` falls.
- R9: A reset during either stage discards all progress, and the full sequence starts again from the watchdog stage.
- R10: A wake pulse while `cpu_run` is high has no effect. A sleep request while `cpu_run` is high lowers `cpu_run` in the next cycle. A sleep request during a start-up stage is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; also starts the full sequence |
| wake | input | 1 | Wake-up pulse from sleep |
| sleep_enter | input | 1 | Request to halt the core and enter sleep |
| src_sel | input | 4 | Clock-source select code |
| sut_sel | input | 2 | Start-up select code |
| osc_tick | input | 1 | One-cycle enable per oscillator cycle |
| wdt_tick | input | 1 | One-cycle enable per watchdog-oscillator cycle |
| cpu_run | output | 1 | High when the core may execute |

## Verification
The assertions assume that `src_sel` and `sut_sel` hold steady for the whole of a sequence. They also assume that ticks, wake pulses and sleep requests are plain single-cycle enables, and that a sleep request reaches the block only through the run state. The stimulus changes the selection inputs only while `rst` is held high. It drives every input at the falling clock edge, with deliberately mixed tick patterns: both tick kinds together, and tick kinds that do not belong to the current stage. Those patterns show whether a stage counts the wrong source.

// File: rtl/startup_hold_pkg.sv
package startup_hold_pkg;

    typedef enum logic [2:0] {
        OSC_MIN_LEN,
        OSC_RC_LEN,
        OSC_FAST_LEN,
        OSC_1K_LEN,
        OSC_16K_LEN,
        OSC_32K_LEN
    } osc_len_e;

    typedef enum logic [1:0] {
        WDT_NONE,
        WDT_SHORT_LEN,
        WDT_LONG_LEN
    } wdt_len_e;

    typedef struct packed {
        osc_len_e osc;
        wdt_len_e wdt;
    } hold_cfg_t;

    typedef enum logic [1:0] {
        ST_WDT,
        ST_OSC,
        ST_RUN,
        ST_SLEEP
    } hold_state_e;

    localparam logic [3:0] SRC_XTAL_LO = 4'd10;
    localparam logic [3:0] SRC_LFX     = 4'd9;
    localparam logic [3:0] SRC_ERC_LO  = 4'd5;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic hold_cfg_t decode_fuses(input logic [3:0] src, input logic [1:0] sut);
        hold_cfg_t c;
        logic [2:0] idx;
        idx = {src[0], sut};
        c   = '{osc: OSC_MIN_LEN, wdt: WDT_LONG_LEN};
        if (src >= SRC_XTAL_LO) begin
            case (idx)
                3'd0:    c = '{osc: OSC_FAST_LEN, wdt: WDT_SHORT_LEN};
                3'd1:    c = '{osc: OSC_FAST_LEN, wdt: WDT_LONG_LEN};
                3'd2:    c = '{osc: OSC_1K_LEN,   wdt: WDT_NONE};
                3'd3:    c = '{osc: OSC_1K_LEN,   wdt: WDT_SHORT_LEN};
                3'd4:    c = '{osc: OSC_1K_LEN,   wdt: WDT_LONG_LEN};
                3'd5:    c = '{osc: OSC_16K_LEN,  wdt: WDT_NONE};
                3'd6:    c = '{osc: OSC_16K_LEN,  wdt: WDT_SHORT_LEN};
                default: c = '{osc: OSC_16K_LEN,  wdt: WDT_LONG_LEN};
            endcase
        end else if (src == SRC_LFX) begin
            case (sut)
                2'd0:    c = '{osc: OSC_1K_LEN,  wdt: WDT_SHORT_LEN};
                2'd1:    c = '{osc: OSC_1K_LEN,  wdt: WDT_LONG_LEN};
                default: c = '{osc: OSC_32K_LEN, wdt: WDT_LONG_LEN};
            endcase
        end else if (src >= SRC_ERC_LO) begin
            case (sut)
                2'd0:    c = '{osc: OSC_RC_LEN,  wdt: WDT_NONE};
                2'd1:    c = '{osc: OSC_RC_LEN,  wdt: WDT_SHORT_LEN};
                2'd2:    c = '{osc: OSC_RC_LEN,  wdt: WDT_LONG_LEN};
                default: c = '{osc: OSC_MIN_LEN, wdt: WDT_SHORT_LEN};
            endcase
        end else begin
            case (sut)
                2'd0:    c = '{osc: OSC_MIN_LEN, wdt: WDT_NONE};
                2'd1:    c = '{osc: OSC_MIN_LEN, wdt: WDT_SHORT_LEN};
                default: c = '{osc: OSC_MIN_LEN, wdt: WDT_LONG_LEN};
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/startup_len_decode.sv
module startup_len_decode
    import startup_hold_pkg::*;
#(
    parameter int unsigned CNT_W     = 17,
    parameter int unsigned OSC_MIN   = 6,
    parameter int unsigned OSC_RC    = 18,
    parameter int unsigned OSC_FAST  = 258,
    parameter int unsigned OSC_1K    = 1024,
    parameter int unsigned OSC_16K   = 16384,
    parameter int unsigned OSC_32K   = 32768,
    parameter int unsigned WDT_SHORT = 4096,
    parameter int unsigned WDT_LONG  = 65536
) (
    input  logic [3:0]       src_sel,
    input  logic [1:0]       sut_sel,
    output logic [CNT_W-1:0] osc_tgt,
    output logic [CNT_W-1:0] wdt_tgt
);
    hold_cfg_t cfg;

    always_comb begin
        cfg = decode_fuses(src_sel, sut_sel);
        case (cfg.osc)
            OSC_RC_LEN:   osc_tgt = CNT_W'(OSC_RC);
            OSC_FAST_LEN: osc_tgt = CNT_W'(OSC_FAST);
            OSC_1K_LEN:   osc_tgt = CNT_W'(OSC_1K);
            OSC_16K_LEN:  osc_tgt = CNT_W'(OSC_16K);
            OSC_32K_LEN:  osc_tgt = CNT_W'(OSC_32K);
            default:      osc_tgt = CNT_W'(OSC_MIN);
        endcase
        case (cfg.wdt)
            WDT_SHORT_LEN: wdt_tgt = CNT_W'(WDT_SHORT);
            WDT_LONG_LEN:  wdt_tgt = CNT_W'(WDT_LONG);
            default:       wdt_tgt = '0;
        endcase
    end
endmodule

// File: rtl/startup_tick_counter.sv
module startup_tick_counter #(
    parameter int unsigned CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/startup_seq_fsm.sv
module startup_seq_fsm
    import startup_hold_pkg::*;
#(
    parameter int unsigned CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wake,
    input  logic             sleep_enter,
    input  logic             osc_tick,
    input  logic             wdt_tick,
    input  logic [CNT_W-1:0] osc_tgt,
    input  logic [CNT_W-1:0] wdt_tgt,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             run
);
    hold_state_e state;
    logic        wdt_last;
    logic        osc_last;

    always_comb begin
        wdt_last = (state == ST_WDT) && wdt_tick && (cnt == wdt_tgt - CNT_W'(1));
        osc_last = (state == ST_OSC) && osc_tick && (cnt == osc_tgt - CNT_W'(1));
        cnt_inc  = ((state == ST_WDT) && wdt_tick && !wdt_last) ||
                   ((state == ST_OSC) && osc_tick && !osc_last);
        cnt_clr  = wdt_last || osc_last || ((state == ST_SLEEP) && wake);
        run      = (state == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= (wdt_tgt == '0) ? ST_OSC : ST_WDT;
        end else begin
            case (state)
                ST_WDT:   if (wdt_last) state <= ST_OSC;
                ST_OSC:   if (osc_last) state <= ST_RUN;
                ST_RUN:   if (sleep_enter) state <= ST_SLEEP;
                default:  if (wake) state <= ST_OSC;
            endcase
        end
    end
endmodule

// File: rtl/startup_hold.sv
module startup_hold
    import startup_hold_pkg::*;
#(
    parameter int unsigned OSC_MIN   = 6,
    parameter int unsigned OSC_RC    = 18,
    parameter int unsigned OSC_FAST  = 258,
    parameter int unsigned OSC_1K    = 1024,
    parameter int unsigned OSC_16K   = 16384,
    parameter int unsigned OSC_32K   = 32768,
    parameter int unsigned WDT_SHORT = 4096,
    parameter int unsigned WDT_LONG  = 65536
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wake,
    input  logic       sleep_enter,
    input  logic [3:0] src_sel,
    input  logic [1:0] sut_sel,
    input  logic       osc_tick,
    input  logic       wdt_tick,
    output logic       cpu_run
);
    localparam int unsigned MAX_OSC = max_u(max_u(max_u(OSC_MIN, OSC_RC), max_u(OSC_FAST, OSC_1K)),
                                            max_u(OSC_16K, OSC_32K));
    localparam int unsigned MAX_CNT = max_u(MAX_OSC, max_u(WDT_SHORT, WDT_LONG));
    localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);

    logic [CNT_W-1:0] osc_tgt;
    logic [CNT_W-1:0] wdt_tgt;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             cnt_inc;

    startup_len_decode #(
        .CNT_W(CNT_W), .OSC_MIN(OSC_MIN), .OSC_RC(OSC_RC), .OSC_FAST(OSC_FAST),
        .OSC_1K(OSC_1K), .OSC_16K(OSC_16K), .OSC_32K(OSC_32K),
        .WDT_SHORT(WDT_SHORT), .WDT_LONG(WDT_LONG)
    ) u_decode (
        .src_sel (src_sel),
        .sut_sel (sut_sel),
        .osc_tgt (osc_tgt),
        .wdt_tgt (wdt_tgt)
    );

    startup_tick_counter #(.CNT_W(CNT_W)) u_count (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .inc (cnt_inc),
        .cnt (cnt)
    );

    startup_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .wake        (wake),
        .sleep_enter (sleep_enter),
        .osc_tick    (osc_tick),
        .wdt_tick    (wdt_tick),
        .osc_tgt     (osc_tgt),
        .wdt_tgt     (wdt_tgt),
        .cnt         (cnt),
        .cnt_clr     (cnt_clr),
        .cnt_inc     (cnt_inc),
        .run         (cpu_run)
    );
endmodule

// File: rtl/startup_hold_chk.sv
module startup_hold_chk (
    input logic clk,
    input logic rst,
    input logic wake,
    input logic sleep_enter,
    input logic osc_tick,
    input logic cpu_run
);
    p_reset_clears_r1: assert property (@(posedge clk) rst |=> !cpu_run);

    p_rise_on_osc_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_run) |-> $past(osc_tick));

    p_wake_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (cpu_run && wake && !sleep_enter) |=> cpu_run);

    p_sleep_drops_r10: assert property (@(posedge clk) disable iff (rst)
        (cpu_run && sleep_enter) |=> !cpu_run);

    p_fall_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_run) |-> ($past(sleep_enter) || $past(rst)));
endmodule

bind startup_hold startup_hold_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wake        (wake),
    .sleep_enter (sleep_enter),
    .osc_tick    (osc_tick),
    .cpu_run     (cpu_run)
);

// File: tb/startup_hold_test.sv
module startup_hold_test;
    localparam int O_MIN = 2, O_RC = 3, O_FAST = 4, O_1K = 5, O_16K = 7, O_32K = 8;
    localparam int W_S = 3, W_L = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wake = 1'b0;
    logic       sleep_enter = 1'b0;
    logic [3:0] src_sel = 4'd1;
    logic [1:0] sut_sel = 2'd2;
    logic       osc_tick = 1'b0;
    logic       wdt_tick = 1'b0;
    logic       cpu_run;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    startup_hold #(
        .OSC_MIN(O_MIN), .OSC_RC(O_RC), .OSC_FAST(O_FAST), .OSC_1K(O_1K),
        .OSC_16K(O_16K), .OSC_32K(O_32K), .WDT_SHORT(W_S), .WDT_LONG(W_L)
    ) uut (
        .clk(clk), .rst(rst), .wake(wake), .sleep_enter(sleep_enter),
        .src_sel(src_sel), .sut_sel(sut_sel), .osc_tick(osc_tick),
        .wdt_tick(wdt_tick), .cpu_run(cpu_run)
    );

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: cpu_run=%0b expected %0b (src=%0d sut=%0d)",
                     req, what, got, exp, src_sel, sut_sel);
        end
    endtask

    task automatic step(input logic o, input logic w, input logic wk, input logic sl, input logic r);
        @(negedge clk);
        osc_tick = o; wdt_tick = w; wake = wk; sleep_enter = sl; rst = r;
        @(posedge clk);
        #1;
    endtask

    // Expected lengths from the selection tables
    task automatic expect_len(input int src, input int sut, output int o, output int w, output string fam);
        int idx;
        if (src >= 10) begin
            fam = "R4";
            idx = (src % 2) * 4 + sut;
            o = (idx < 2) ? O_FAST : (idx < 5) ? O_1K : O_16K;
            if (idx < 2) w = (idx == 0) ? W_S : W_L;
            else w = ((idx - 2) % 3 == 0) ? 0 : ((idx - 2) % 3 == 1) ? W_S : W_L;
        end else if (src == 9) begin
            fam = "R5";
            o = (sut < 2) ? O_1K : O_32K;
            w = (sut == 0) ? W_S : W_L;
        end else if (src >= 5) begin
            fam = "R6";
            o = (sut == 3) ? O_MIN : O_RC;
            w = (sut == 0) ? 0 : (sut == 2) ? W_L : W_S;
        end else begin
            fam = "R7";
            o = O_MIN;
            w = (sut == 0) ? 0 : (sut == 1) ? W_S : W_L;
        end
    endtask

    task automatic run_cfg(input int src, input int sut);
        int o, w;
        string fam;
        expect_len(src, sut, o, w, fam);
        @(negedge clk);
        rst = 1'b1;
        src_sel = 4'(src);
        sut_sel = 2'(sut);
        step(0, 0, 0, 0, 1);
        chk(cpu_run, 1'b0, "R1", "held in reset");
        step(0, 0, 0, 0, 0);
        chk(cpu_run, 1'b0, "R1", "cycle after reset");
        for (int i = 0; i < w; i++) begin
            step(1, 0, 0, 0, 0);
            step(1, 1, 0, 0, 0);
        end
        chk(cpu_run, 1'b0, "R2", "oscillator ticks counted during watchdog stage");
        for (int i = 0; i < o; i++) begin
            step(0, 1, 0, 0, 0);
            chk(cpu_run, 1'b0, "R2", "watchdog tick counted in oscillator stage");
            step(1, 1, 0, 0, 0);
            if (i < o - 1) chk(cpu_run, 1'b0, "R2", "run before final oscillator tick");
            else if (w == 0) chk(cpu_run, 1'b1, "R8", "zero watchdog length sequence");
            else chk(cpu_run, 1'b1, fam, "run after selected lengths");
        end
        step(0, 0, 1, 0, 0);
        chk(cpu_run, 1'b1, "R10", "wake while running");
        step(0, 0, 0, 1, 0);
        chk(cpu_run, 1'b0, "R10", "sleep request");
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0);
        chk(cpu_run, 1'b0, "R3", "ticks while asleep");
        step(0, 0, 1, 0, 0);
        for (int i = 0; i < o; i++) begin
            step(0, 1, 0, 0, 0);
            step(1, 0, 0, 0, 0);
            if (i < o - 1) chk(cpu_run, 1'b0, "R3", "wake run before final tick");
            else chk(cpu_run, 1'b1, "R3", "wake run after oscillator stage");
        end
    endtask

    initial begin
        repeat (2) step(0, 0, 0, 0, 1);
        chk(cpu_run, 1'b0, "R1", "initial reset");
        for (int s = 0; s < 16; s++)
            for (int u = 0; u < 4; u++)
                run_cfg(s, u);

        // R9: reset mid-stage restarts; default setting 1/2 -> W_L then O_MIN (R7)
        @(negedge clk);
        src_sel = 4'd1; sut_sel = 2'd2;
        step(0, 0, 0, 0, 1);
        for (int i = 0; i < W_L - 1; i++) step(0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        chk(cpu_run, 1'b0, "R9", "reset in watchdog stage");
        for (int i = 0; i < W_L - 1; i++) step(0, 1, 0, 0, 0);
        for (int i = 0; i < O_MIN + 2; i++) step(1, 0, 0, 0, 0);
        chk(cpu_run, 1'b0, "R9", "watchdog progress kept across reset");
        step(0, 1, 0, 0, 0);
        step(1, 0, 0, 1, 0);
        chk(cpu_run, 1'b0, "R10", "sleep request in oscillator stage");
        step(0, 0, 0, 0, 1);
        for (int i = 0; i < W_L; i++) step(0, 1, 0, 0, 0);
        for (int i = 0; i < O_MIN - 1; i++) step(1, 0, 0, 0, 0);
        chk(cpu_run, 1'b0, "R9", "oscillator progress kept across reset");
        step(1, 0, 0, 1, 0);
        chk(cpu_run, 1'b1, "R7", "default setting length");
        step(0, 0, 0, 0, 0);
        chk(cpu_run, 1'b1, "R10", "sleep during stage ignored");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule